// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block issues the multi-write command sequences that a 16-bit parallel NOR flash expects before it accepts an unlock, protection or similar command. The flash is word addressed: a word address N sits at system byte offset 2N. The flash's address pins therefore connect to system byte-address bits [24:1]. The sequencer drives word addresses directly and never generates byte-level or width-adapted cycles.

A host supplies an 8-bit command byte and three timing counts, then pulses a start strobe. The block emits exactly three writes, each with its own chip-enable and write-enable strobe. The first two writes carry the fixed key words. The third carries the command byte. The host's setup, write-pulse and hold counts shape every write. Chip enable and write enable return high for one clock between writes. Busy covers the whole sequence, and a one-clock done pulse marks its end.

Top module: `flcmd_seq_top`

## Requirements
- R1: The three writes occur in this order: word address 0x555 with data 0x00AA, then 0x2AA with 0x0055, then 0x555 with data bits [7:0] equal to the captured command byte and bits [15:8] equal to zero.
- R2: Exactly three writes are issued per start, none skipped or merged. Write enable (active low) is low only while chip enable (active low) is also low.
- R3: Before write enable falls, chip enable is low with write enable high for max(1, setup count) clocks. Address and data stay stable while chip enable is low.
- R4: Write enable stays low for max(1, pulse count) clocks in each write.
- R5: After write enable rises, chip enable stays low with address and data unchanged for max(1, hold count) clocks.
- R6: Between consecutive writes, chip enable and write enable are both high for exactly one clock.
- R7: Start is accepted only when busy is low. A start while busy has no effect on the running sequence, and no second sequence follows it.
- R8: Busy rises on the clock after an accepted start and stays high for 3*(S+P+H)+2 clocks, where S, P and H are the effective counts.
- R9: Done is high for exactly one clock, in the first clock where busy is low after a sequence.
- R10: In reset and while idle: chip enable high, write enable high, busy low, done low, and address and data zero. Reset is synchronous and active low, and it aborts a running sequence.
- R11: The command byte and the timing counts are captured when start is accepted. Later changes to those inputs have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| cmd_i | input | 8 | Command byte for the third write |
| setup_cnt_i | input | 8 | Setup clocks before write enable falls (0 acts as 1) |
| pulse_cnt_i | input | 8 | Write-enable low clocks (0 acts as 1) |
| hold_cnt_i | input | 8 | Hold clocks after write enable rises (0 acts as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse when the sequence ends |
| flash_addr_o | output | 24 | Flash word address |
| flash_data_o | output | 16 | Flash write data |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| flash_we_n_o | output | 1 | Flash write enable, active low |

## Verification
The bench reconstructs every write from the flash pins. For each write it counts setup, pulse, hold and gap clocks and captures address and data, so a design that drops or merges the second (odd-key) write is caught. A wrong phase length or a missing inter-write gap is also caught. Zero timing counts check the treat-as-one rule; a design that wraps or skips a phase there would show a zero or huge count. A mid-sequence start with altered inputs exposes a design that restarts, takes a new command byte or re-reads its timing live. A mid-sequence reset exposes a design that leaves chip enable or write enable asserted.

// File: rtl/flcmd_pkg.sv
// Package: shared phase type and sequence constants for the flash command sequencer.
// Assumes a fixed three-write sequence; the step index is sized to hold it.
package flcmd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_GAP
    } phase_e;

    localparam int unsigned NUM_WRITES = 3;
    localparam int unsigned STEP_W     = $clog2(NUM_WRITES);
endpackage

// File: rtl/flcmd_step_decode.sv
// Maps a write step index to the flash word address and data of that write.
// Assumes step 0 and 1 are the key writes and any later step is the command write;
// the command byte is zero-extended into the data word.
module flcmd_step_decode
    import flcmd_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 24,
    parameter int unsigned     DATA_W     = 16,
    parameter int unsigned     CMD_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 24'h000555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 24'h0002AA,
    parameter logic [CMD_W-1:0]  KEY_DATA_A = 8'hAA,
    parameter logic [CMD_W-1:0]  KEY_DATA_B = 8'h55
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int unsigned PAD_W = DATA_W - CMD_W;

    // Select address and zero-extended data byte for the current step.
    always_comb begin
        unique case (step_i)
            STEP_W'(0): begin
                addr_o = KEY_ADDR_A;
                data_o = {{PAD_W{1'b0}}, KEY_DATA_A};
            end
            STEP_W'(1): begin
                addr_o = KEY_ADDR_B;
                data_o = {{PAD_W{1'b0}}, KEY_DATA_B};
            end
            default: begin
                addr_o = KEY_ADDR_A;
                data_o = {{PAD_W{1'b0}}, cmd_i};
            end
        endcase
    end
endmodule

// File: rtl/flcmd_phase_timer.sv
// Counts clocks spent in the current bus phase and flags its final clock.
// Assumes the owner pulses restart_i on the edge that enters a new phase;
// a requested length of zero is treated as one. The counter saturates.
module flcmd_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_len;

    // Clamp a zero length to one clock.
    always_comb eff_len = (len_i == '0) ? ONE : len_i;

    // Clock count within the phase, starting at one on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= ONE;
        else if (restart_i)      cnt_q <= ONE;
        else if (cnt_q != MAX)   cnt_q <= cnt_q + ONE;
    end

    // Final clock of the phase.
    always_comb last_o = (cnt_q == eff_len);
endmodule

// File: rtl/flcmd_seq_top.sv
// Flash command sequencer: on an accepted start, issues three individually strobed
// 16-bit word writes (two key writes, then the command write) with programmable
// setup, pulse and hold clocks and a one-clock idle gap between writes.
// Assumes inputs are synchronous to clk; the strobes are decoded from registered state.
module flcmd_seq_top
    import flcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CMD_W  = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [CNT_W-1:0]  setup_cnt_i,
    input  logic [CNT_W-1:0]  pulse_cnt_i,
    input  logic [CNT_W-1:0]  hold_cnt_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic [DATA_W-1:0] flash_data_o,
    output logic              flash_ce_n_o,
    output logic              flash_we_n_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WRITES - 1);

    phase_e            phase_q, phase_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [CMD_W-1:0]  cmd_q;
    logic [CNT_W-1:0]  setup_q, pulse_q, hold_q;
    logic              done_q, done_d;
    logic              restart;
    logic              load;
    logic              last;
    logic [CNT_W-1:0]  len_sel;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_data;

    // Length of the phase currently being timed.
    always_comb begin
        unique case (phase_q)
            PH_SETUP: len_sel = setup_q;
            PH_PULSE: len_sel = pulse_q;
            PH_HOLD:  len_sel = hold_q;
            default:  len_sel = CNT_W'(1);
        endcase
    end

    flcmd_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .len_i     (len_sel),
        .last_o    (last)
    );

    flcmd_step_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W)
    ) decode_i (
        .step_i (step_q),
        .cmd_i  (cmd_q),
        .addr_o (dec_addr),
        .data_o (dec_data)
    );

    // Next phase, step and done pulse.
    always_comb begin
        phase_d = phase_q;
        step_d  = step_q;
        restart = 1'b0;
        load    = 1'b0;
        done_d  = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (start_i) begin
                phase_d = PH_SETUP;
                step_d  = '0;
                restart = 1'b1;
                load    = 1'b1;
            end
            PH_SETUP: if (last) begin
                phase_d = PH_PULSE;
                restart = 1'b1;
            end
            PH_PULSE: if (last) begin
                phase_d = PH_HOLD;
                restart = 1'b1;
            end
            PH_HOLD: if (last) begin
                restart = 1'b1;
                if (step_q == LAST_STEP) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end else begin
                    phase_d = PH_GAP;
                end
            end
            PH_GAP: if (last) begin
                phase_d = PH_SETUP;
                step_d  = step_q + STEP_W'(1);
                restart = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
            done_q  <= done_d;
        end
    end

    // Capture command byte and timing counts on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            setup_q <= '0;
            pulse_q <= '0;
            hold_q  <= '0;
        end else if (load) begin
            cmd_q   <= cmd_i;
            setup_q <= setup_cnt_i;
            pulse_q <= pulse_cnt_i;
            hold_q  <= hold_cnt_i;
        end
    end

    // Pin decode from the registered phase.
    always_comb begin
        busy_o       = (phase_q != PH_IDLE);
        done_o       = done_q;
        flash_ce_n_o = (phase_q == PH_IDLE) || (phase_q == PH_GAP);
        flash_we_n_o = (phase_q != PH_PULSE);
        flash_addr_o = busy_o ? dec_addr : '0;
        flash_data_o = busy_o ? dec_data : '0;
    end
endmodule

// File: rtl/flcmd_seq_chk.sv
// Checker for the flash command sequencer, attached by bind; observes ports only.
module flcmd_seq_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] flash_addr_o,
    input logic [DATA_W-1:0] flash_data_o,
    input logic              flash_ce_n_o,
    input logic              flash_we_n_o
);
    p_we_within_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n_o |-> !flash_ce_n_o);

    p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n_o && $past(!flash_ce_n_o)) |-> ($stable(flash_addr_o) && $stable(flash_data_o)));

    p_upper_data_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n_o |-> (flash_data_o[DATA_W-1:8] == '0));

    p_single_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flash_ce_n_o) && busy_o) |=> !flash_ce_n_o);

    p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (flash_ce_n_o && flash_we_n_o));
endmodule

bind flcmd_seq_top flcmd_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .flash_addr_o (flash_addr_o),
    .flash_data_o (flash_data_o),
    .flash_ce_n_o (flash_ce_n_o),
    .flash_we_n_o (flash_we_n_o)
);

// File: tb/flcmd_seq_top_tb_top.sv
`timescale 1ns/1ps
module flcmd_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd = '0;
    logic [7:0]  s_cnt = '0, p_cnt = '0, h_cnt = '0;
    logic        busy, done;
    logic [23:0] addr;
    logic [15:0] data;
    logic        ce_n, we_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    flcmd_seq_top dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start), .cmd_i (cmd),
        .setup_cnt_i (s_cnt), .pulse_cnt_i (p_cnt), .hold_cnt_i (h_cnt),
        .busy_o (busy), .done_o (done), .flash_addr_o (addr), .flash_data_o (data),
        .flash_ce_n_o (ce_n), .flash_we_n_o (we_n)
    );

    // Vectors: {command byte, setup, pulse, hold}
    localparam logic [31:0] VEC [6] = '{
        {8'hE0, 8'd1, 8'd1, 8'd1},
        {8'h90, 8'd2, 8'd3, 8'd1},
        {8'hA0, 8'd0, 8'd0, 8'd0},
        {8'h30, 8'd4, 8'd1, 8'd5},
        {8'hF0, 8'd1, 8'd6, 8'd2},
        {8'h00, 8'd3, 8'd2, 8'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    task automatic check_idle(input string req);
        chk(ce_n === 1'b1 && we_n === 1'b1, req, "strobes high when idle", {ce_n, we_n}, 2'b11);
        chk(busy === 1'b0 && done === 1'b0, req, "busy/done low when idle", {busy, done}, 2'b00);
        chk(addr === '0 && data === '0, req, "addr/data zero when idle", {addr, data}, 0);
    endtask

    // Run one sequence and reconstruct the writes from the pins.
    // poke: mid-run start with changed inputs (R7, R11).
    task automatic run_seq(input logic [7:0] c, input logic [7:0] s, input logic [7:0] p,
                           input logic [7:0] h, input bit poke);
        int es = (s == 0) ? 1 : int'(s);
        int ep = (p == 0) ? 1 : int'(p);
        int eh = (h == 0) ? 1 : int'(h);
        int w = 0;
        int setup_n[4], pulse_n[4], hold_n[4], gap_n[4];
        logic [23:0] a_cap[4];
        logic [15:0] d_cap[4];
        int busy_n = 0, done_n = 0, k = 0;
        bit prev_low = 0, stab_bad = 0, we_wo_ce = 0, done_at_end = 0;
        logic [23:0] exp_a[3];
        logic [15:0] exp_d[3];
        exp_a = '{24'h555, 24'h2AA, 24'h555};
        exp_d = '{16'h00AA, 16'h0055, {8'h00, c}};
        for (int i = 0; i < 4; i++) begin
            setup_n[i] = 0; pulse_n[i] = 0; hold_n[i] = 0; gap_n[i] = 0;
            a_cap[i] = '0; d_cap[i] = '0;
        end
        @(negedge clk);
        start = 1'b1; cmd = c; s_cnt = s; p_cnt = p; h_cnt = h;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            if (poke && k == 2) begin
                start = 1'b1; cmd = 8'h3C; s_cnt = 8'd9; p_cnt = 8'd9; h_cnt = 8'd9;
            end
            if (poke && k == 3) start = 1'b0;
            if (busy) busy_n++;
            if (done) begin
                done_n++;
                if (!busy) done_at_end = 1;
            end
            if (!ce_n) begin
                if (w < 4) begin
                    if (!we_n) pulse_n[w]++;
                    else if (pulse_n[w] == 0) setup_n[w]++;
                    else hold_n[w]++;
                    if (prev_low && (addr !== a_cap[w] || data !== d_cap[w])) stab_bad = 1;
                    a_cap[w] = addr;
                    d_cap[w] = data;
                end
                prev_low = 1;
            end else begin
                if (!we_n) we_wo_ce = 1;
                if (prev_low) w++;
                if (busy && w < 4) gap_n[w]++;
                prev_low = 0;
            end
            if (!busy) break;
            k++;
            @(negedge clk);
        end
        chk(w == 3, "R2", "write count", w, 3);
        chk(!we_wo_ce, "R2", "we low without ce", we_wo_ce, 0);
        for (int i = 0; i < 3; i++) begin
            chk(a_cap[i] == exp_a[i], "R1", $sformatf("write %0d address", i), a_cap[i], exp_a[i]);
            chk(d_cap[i] == exp_d[i], "R1", $sformatf("write %0d data", i), d_cap[i], exp_d[i]);
            chk(setup_n[i] == es, "R3", $sformatf("write %0d setup clocks", i), setup_n[i], es);
            chk(pulse_n[i] == ep, "R4", $sformatf("write %0d pulse clocks", i), pulse_n[i], ep);
            chk(hold_n[i] == eh, "R5", $sformatf("write %0d hold clocks", i), hold_n[i], eh);
        end
        chk(!stab_bad, "R3", "addr/data stable while ce low", stab_bad, 0);
        chk(gap_n[1] == 1 && gap_n[2] == 1, "R6", "gap clocks", {gap_n[1][7:0], gap_n[2][7:0]}, 16'h0101);
        chk(busy_n == 3 * (es + ep + eh) + 2, "R8", "busy length", busy_n, 3 * (es + ep + eh) + 2);
        chk(done_n == 1 && done_at_end, "R9", "done pulse at busy fall", done_n, 1);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done one clock", done, 0);
        chk(busy === 1'b0, "R7", "no second sequence", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10");

        // Table-driven runs: R1..R6, R8, R9
        for (int i = 0; i < 6; i++) begin
            run_seq(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
        end

        // R7 and R11: start and changed inputs while busy are ignored
        run_seq(8'hE0, 8'd2, 8'd2, 8'd2, 1'b1);
        check_idle("R7");

        // R10: reset in the middle of a sequence aborts it
        @(negedge clk);
        start = 1'b1; cmd = 8'h55; s_cnt = 8'd3; p_cnt = 8'd3; h_cnt = 8'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(we_n === 1'b0 && busy === 1'b1, "R4", "mid-run pulse before reset", {busy, we_n}, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10");

        // Recovery after reset
        run_seq(8'hC1, 8'd1, 8'd2, 8'd3, 1'b0);

        finish_run();
    end
endmodule